// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This controller walks a CPU clock domain from one operating rate to another while the domain's main PLL is reprogrammed. A request carries the present (old) rate and the target (new) rate. The block first looks up the target rate in a small table. It then moves the core clock mux onto an alternate source. If that alternate source runs faster than the old rate, the block divides it down so the core never runs faster than it did before the change. Next it asks the PLL to retune and waits for lock. Last, it returns the mux to the main source and applies the target entry's auxiliary divider settings. These settings come before the switch-back when the rate rises and after it when the rate falls.

All register traffic leaves through one write port with an address, data and a per-bit write mask, the form used by hi-word-masked control registers. In the core control register, bits [DIV_W-1:0] hold the core divider and bit DIV_W holds the mux select (1 = alternate, 0 = main). The block keeps a shadow of that register and reports the resulting core rate.

Top module: `cpu_rate_seq`

## Requirements
- R1: The new rate is matched exactly against the table entries; the matching entry's auxiliary writes are the ones issued later in the sequence.
- R2: A new rate that matches no entry produces no write at all, pulses `done`, sets `err_badrate`, and leaves the reported core rate unchanged.
- R3: When the alternate rate exceeds the old rate, the pre-change write goes to `CORE_ADDR` with mux bit DIV_W = 1 and divider bits = ceil(alt/old) - 1, both in one write whose mask covers bits [DIV_W:0].
- R4: The computed alternate divider is clamped to 2^DIV_W - 1.
- R5: When the alternate rate does not exceed the old rate, the pre-change write sets only the mux: mask bit DIV_W alone, data bit DIV_W = 1, and the divider field is left as it was.
- R6: After the pre-change write, `pll_req` stays high until `pll_locked` is seen. If lock does not arrive within `PLL_TIMEOUT` cycles, the sequence ends with `err_timeout` set, no further write, and the mux left on the alternate source.
- R7: The switch-back is a single write to `CORE_ADDR` with data bits [DIV_W:0] = 0 and mask bits [DIV_W:0] all set.
- R8: When the new rate is above the old rate, the entry's auxiliary writes, in index order and with a full mask, come before the switch-back.
- R9: When the new rate is below the old rate, the auxiliary writes come after the switch-back. When the two rates are equal, no auxiliary write is made.
- R10: Auxiliary slots whose address is 0 produce no write.
- R11: `core_rate` equals the parent rate divided by (divider field + 1). The parent is the latched alternate rate while the mux is on the alternate source. Otherwise it is the main rate, which is 0 after reset, the old rate once a request is accepted, and the new rate once lock is seen.
- R12: After reset, `busy`, `wr_en` and `pll_req` are low and `core_rate` is 0. `busy` stays high from acceptance to the end of the sequence, and requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Rate-change request strobe |
| req_old_rate | input | RATE_W | Rate in force before the change |
| req_new_rate | input | RATE_W | Target rate |
| alt_rate | input | RATE_W | Rate of the alternate clock source |
| tbl_rate | input | N_RATES*RATE_W | Table rates, entry e at [e*RATE_W +: RATE_W] |
| tbl_aux_addr | input | N_RATES*N_AUX*ADDR_W | Auxiliary write addresses, slot e*N_AUX+j |
| tbl_aux_data | input | N_RATES*N_AUX*DATA_W | Auxiliary write data, slot e*N_AUX+j |
| pll_req | output | 1 | PLL reprogram request |
| pll_locked | input | 1 | PLL lock indication |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | DATA_W | Register write data |
| wr_mask | output | DATA_W | Per-bit write enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| err_badrate | output | 1 | Last request had no table match |
| err_timeout | output | 1 | Last request timed out waiting for lock |
| core_rate | output | RATE_W | Rate implied by the shadow core register |

## Verification
The hardest state to reach is a sequence that starts with the divider field already nonzero. This happens only after a lock timeout has left the mux parked on a divided alternate source. A following request whose alternate rate is below the old rate then performs a mux-only write, and the stale divider must stay in effect. The bench reaches this state by first issuing a request with a fast alternate source and never raising lock. It then issues a slow-alternate request and checks the reported core rate while the PLL wait is in progress. A second hard case is a request that arrives while busy. The bench injects one during the PLL wait and confirms that the write stream still matches the original request.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_DIVIDE,
    ST_PRE,
    ST_WAIT,
    ST_AUX,
    ST_BACK
  } seq_state_e;

endpackage

// File: rtl/crs_div_unit.sv
// Iterative ceiling divider: result = min(ceil(num/den) - 1, 2^DIV_W - 1).
module crs_div_unit #(
  parameter int RATE_W = 16,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] num,
  input  logic [RATE_W-1:0] den,
  output logic              done,
  output logic [DIV_W-1:0]  result
);
  localparam int CNT_W = DIV_W + 1;
  localparam logic [CNT_W-1:0] CAP = CNT_W'(1) << DIV_W;

  logic [RATE_W-1:0] rem_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q, done_q;
  logic [DIV_W-1:0]  res_q;
  logic              finish;

  // Quotient count to divider field; a count at CAP lands on the field maximum.
  function automatic logic [DIV_W-1:0] count_to_div(input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] m;
    m = (c == '0) ? '0 : c - CNT_W'(1);
    return m[DIV_W-1:0];
  endfunction

  assign finish = run_q && ((rem_q == '0) || (cnt_q == CAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else if (start) begin
      rem_q  <= num;
      cnt_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (finish) begin
      run_q  <= 1'b0;
      done_q <= 1'b1;
      res_q  <= count_to_div(cnt_q);
    end else begin
      done_q <= 1'b0;
      if (run_q) begin
        rem_q <= (rem_q > den) ? rem_q - den : '0;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign done   = done_q;
  assign result = res_q;

endmodule

// File: rtl/crs_rate_match.sv
// Exact-match lookup of a rate in the table; lowest index wins.
module crs_rate_match #(
  parameter int RATE_W  = 16,
  parameter int N_RATES = 4,
  parameter int IDX_W   = 2
) (
  input  logic [RATE_W-1:0]         rate,
  input  logic [N_RATES*RATE_W-1:0] tbl_rate,
  output logic                      hit,
  output logic [IDX_W-1:0]          idx
);
  logic [N_RATES-1:0] hit_vec;

  for (genvar e = 0; e < N_RATES; e++) begin : g_cmp
    assign hit_vec[e] = (tbl_rate[e*RATE_W +: RATE_W] == rate);
  end

  always_comb begin
    hit = |hit_vec;
    idx = '0;
    for (int e = N_RATES - 1; e >= 0; e--) begin
      if (hit_vec[e]) idx = IDX_W'(e);
    end
  end

endmodule

// File: rtl/cpu_rate_seq.sv
module cpu_rate_seq
  import crs_pkg::*;
#(
  parameter int              RATE_W      = 16,
  parameter int              DIV_W       = 4,
  parameter int              N_RATES     = 4,
  parameter int              N_AUX       = 2,
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 16,
  parameter logic [ADDR_W-1:0] CORE_ADDR = 8'h04,
  parameter int              PLL_TIMEOUT = 1000
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic [RATE_W-1:0]                  req_old_rate,
  input  logic [RATE_W-1:0]                  req_new_rate,
  input  logic [RATE_W-1:0]                  alt_rate,
  input  logic [N_RATES*RATE_W-1:0]          tbl_rate,
  input  logic [N_RATES*N_AUX*ADDR_W-1:0]    tbl_aux_addr,
  input  logic [N_RATES*N_AUX*DATA_W-1:0]    tbl_aux_data,
  output logic                               pll_req,
  input  logic                               pll_locked,
  output logic                               wr_en,
  output logic [ADDR_W-1:0]                  wr_addr,
  output logic [DATA_W-1:0]                  wr_data,
  output logic [DATA_W-1:0]                  wr_mask,
  output logic                               busy,
  output logic                               done,
  output logic                               err_badrate,
  output logic                               err_timeout,
  output logic [RATE_W-1:0]                  core_rate
);
  localparam int IDX_W = (N_RATES > 1) ? $clog2(N_RATES) : 1;
  localparam int AUX_W = (N_AUX > 1) ? $clog2(N_AUX) : 1;
  localparam int TMO_W = $clog2(PLL_TIMEOUT + 1);
  localparam logic [AUX_W-1:0] AUX_LAST = AUX_W'(N_AUX - 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(PLL_TIMEOUT - 1);

  seq_state_e state_q;

  logic [RATE_W-1:0] old_q, new_q, alt_q, main_q;
  logic [IDX_W-1:0]  idx_q;
  logic              up_q, down_q, pre_full_q;
  logic [DIV_W-1:0]  pre_div_q;
  logic [AUX_W-1:0]  aux_j_q;
  logic [TMO_W-1:0]  wait_cnt_q;
  logic              mux_sh_q;
  logic [DIV_W-1:0]  div_sh_q;
  logic              done_q, err_bad_q, err_tmo_q;

  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx;
  logic              div_done;
  logic [DIV_W-1:0]  div_res;
  logic [ADDR_W-1:0] cur_aux_addr;
  logic [DATA_W-1:0] cur_aux_data;

  // Named events, also observed by the checker
  logic ev_accept, ev_reject, ev_div_start, ev_pre_wr, ev_back_wr, ev_aux_wr;
  logic ev_lock, ev_timeout;

  // Core register field images
  function automatic logic [DATA_W-1:0] core_image(input logic mux, input logic [DIV_W-1:0] dv);
    return DATA_W'({mux, dv});
  endfunction

  function automatic logic [DATA_W-1:0] core_mask(input logic with_div);
    logic [DIV_W-1:0] dm;
    dm = with_div ? '1 : '0;
    return DATA_W'({1'b1, dm});
  endfunction

  function automatic logic [RATE_W-1:0] divided_rate(input logic [RATE_W-1:0] parent,
                                                     input logic [DIV_W-1:0]  dv);
    return parent / (RATE_W'(dv) + RATE_W'(1));
  endfunction

  crs_rate_match #(
    .RATE_W (RATE_W),
    .N_RATES(N_RATES),
    .IDX_W  (IDX_W)
  ) i_match (
    .rate    (new_q),
    .tbl_rate(tbl_rate),
    .hit     (lk_hit),
    .idx     (lk_idx)
  );

  crs_div_unit #(
    .RATE_W(RATE_W),
    .DIV_W (DIV_W)
  ) i_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_div_start),
    .num   (alt_q),
    .den   (old_q),
    .done  (div_done),
    .result(div_res)
  );

  always_comb begin
    int unsigned sel;
    sel          = int'(idx_q) * N_AUX + int'(aux_j_q);
    cur_aux_addr = tbl_aux_addr[sel*ADDR_W +: ADDR_W];
    cur_aux_data = tbl_aux_data[sel*DATA_W +: DATA_W];
  end

  assign ev_accept    = (state_q == ST_IDLE) && req_valid;
  assign ev_reject    = (state_q == ST_LOOKUP) && !lk_hit;
  assign ev_div_start = (state_q == ST_LOOKUP) && lk_hit && (alt_q > old_q);
  assign ev_pre_wr    = (state_q == ST_PRE);
  assign ev_back_wr   = (state_q == ST_BACK);
  assign ev_aux_wr    = (state_q == ST_AUX) && (cur_aux_addr != '0);
  assign ev_lock      = (state_q == ST_WAIT) && pll_locked;
  assign ev_timeout   = (state_q == ST_WAIT) && !pll_locked && (wait_cnt_q == TMO_LAST);

  always_comb begin
    wr_en   = ev_pre_wr | ev_back_wr | ev_aux_wr;
    wr_addr = '0;
    wr_data = '0;
    wr_mask = '0;
    if (ev_pre_wr) begin
      wr_addr = CORE_ADDR;
      wr_data = core_image(1'b1, pre_full_q ? pre_div_q : '0);
      wr_mask = core_mask(pre_full_q);
    end else if (ev_back_wr) begin
      wr_addr = CORE_ADDR;
      wr_data = core_image(1'b0, '0);
      wr_mask = core_mask(1'b1);
    end else if (ev_aux_wr) begin
      wr_addr = cur_aux_addr;
      wr_data = cur_aux_data;
      wr_mask = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      old_q      <= '0;
      new_q      <= '0;
      alt_q      <= '0;
      main_q     <= '0;
      idx_q      <= '0;
      up_q       <= 1'b0;
      down_q     <= 1'b0;
      pre_full_q <= 1'b0;
      pre_div_q  <= '0;
      aux_j_q    <= '0;
      wait_cnt_q <= '0;
      mux_sh_q   <= 1'b0;
      div_sh_q   <= '0;
      done_q     <= 1'b0;
      err_bad_q  <= 1'b0;
      err_tmo_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            old_q     <= req_old_rate;
            new_q     <= req_new_rate;
            alt_q     <= alt_rate;
            err_bad_q <= 1'b0;
            err_tmo_q <= 1'b0;
            state_q   <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (!lk_hit) begin
            err_bad_q <= 1'b1;
            done_q    <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            idx_q      <= lk_idx;
            main_q     <= old_q;
            up_q       <= new_q > old_q;
            down_q     <= new_q < old_q;
            pre_full_q <= alt_q > old_q;
            pre_div_q  <= '0;
            state_q    <= (alt_q > old_q) ? ST_DIVIDE : ST_PRE;
          end
        end
        ST_DIVIDE: begin
          if (div_done) begin
            pre_div_q <= div_res;
            state_q   <= ST_PRE;
          end
        end
        ST_PRE: begin
          mux_sh_q <= 1'b1;
          if (pre_full_q) div_sh_q <= pre_div_q;
          wait_cnt_q <= '0;
          state_q    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (pll_locked) begin
            main_q  <= new_q;
            aux_j_q <= '0;
            state_q <= up_q ? ST_AUX : ST_BACK;
          end else if (wait_cnt_q == TMO_LAST) begin
            err_tmo_q <= 1'b1;
            done_q    <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            wait_cnt_q <= wait_cnt_q + TMO_W'(1);
          end
        end
        ST_AUX: begin
          if (aux_j_q == AUX_LAST) begin
            if (up_q) begin
              state_q <= ST_BACK;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else begin
            aux_j_q <= aux_j_q + AUX_W'(1);
          end
        end
        ST_BACK: begin
          mux_sh_q <= 1'b0;
          div_sh_q <= '0;
          aux_j_q  <= '0;
          if (down_q) begin
            state_q <= ST_AUX;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pll_req     = (state_q == ST_WAIT);
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign err_badrate = err_bad_q;
  assign err_timeout = err_tmo_q;
  assign core_rate   = divided_rate(mux_sh_q ? alt_q : main_q, div_sh_q);

endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int              RATE_W    = 16,
  parameter int              DIV_W     = 4,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CORE_ADDR = 8'h04
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err_badrate,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DIV_W:0]    core_data,
  input logic [DIV_W:0]    core_mask,
  input logic              pll_req,
  input logic              pll_locked,
  input logic [RATE_W-1:0] alt_q,
  input logic [RATE_W-1:0] old_q,
  input logic              ev_reject,
  input logic              ev_pre_wr,
  input logic              ev_back_wr,
  input logic              ev_aux_wr,
  input logic              ev_timeout
);

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (!wr_en && done && err_badrate && !busy)); // R2

  AST_PRE_JOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pre_wr && (alt_q > old_q)) |-> ((&core_mask) && core_data[DIV_W] && wr_addr == CORE_ADDR)); // R3

  AST_PRE_MUX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pre_wr && !(alt_q > old_q)) |-> (core_mask[DIV_W-1:0] == '0 && core_mask[DIV_W] && core_data[DIV_W])); // R5

  AST_PLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_req && !pll_locked && !ev_timeout) |=> pll_req); // R6

  AST_BACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_back_wr |-> (core_data == '0 && (&core_mask) && wr_addr == CORE_ADDR)); // R7

  AST_AUX_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_aux_wr |-> (wr_addr != '0)); // R10

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_pre_wr, ev_back_wr, ev_aux_wr})); // R7

  AST_WR_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || pll_req) |-> busy); // R12

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(old_q) && $stable(alt_q))); // R12

endmodule

bind cpu_rate_seq crs_checker #(
  .RATE_W   (RATE_W),
  .DIV_W    (DIV_W),
  .ADDR_W   (ADDR_W),
  .CORE_ADDR(CORE_ADDR)
) i_crs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .err_badrate(err_badrate),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .core_data  (wr_data[DIV_W:0]),
  .core_mask  (wr_mask[DIV_W:0]),
  .pll_req    (pll_req),
  .pll_locked (pll_locked),
  .alt_q      (alt_q),
  .old_q      (old_q),
  .ev_reject  (ev_reject),
  .ev_pre_wr  (ev_pre_wr),
  .ev_back_wr (ev_back_wr),
  .ev_aux_wr  (ev_aux_wr),
  .ev_timeout (ev_timeout)
);

// File: tb/test_cpu_rate_seq.sv
`timescale 1ns/1ps
module test_cpu_rate_seq;
  localparam int RATE_W = 16, DIV_W = 4, N_RATES = 4, N_AUX = 2;
  localparam int ADDR_W = 8, DATA_W = 16, TMO = 40;
  localparam logic [7:0] CORE = 8'h04;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, pll_locked = 1'b0;
  logic [15:0] req_old_rate = '0, req_new_rate = '0, alt_rate = '0;
  logic [N_RATES*RATE_W-1:0]       tbl_rate;
  logic [N_RATES*N_AUX*ADDR_W-1:0] tbl_aux_addr;
  logic [N_RATES*N_AUX*DATA_W-1:0] tbl_aux_data;
  logic pll_req, wr_en, busy, done, err_badrate, err_timeout;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data, wr_mask, core_rate;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // Table: rates 100/200/400/800; aux slots (addr,data), addr 0 = empty
  int t_rate [N_RATES]       = '{100, 200, 400, 800};
  int t_addr [N_RATES*N_AUX] = '{8'h10, 8'h00, 8'h10, 8'h14, 8'h00, 8'h14, 8'h10, 8'h14};
  int t_data [N_RATES*N_AUX] = '{16'h0001, 16'h0EEE, 16'h0002, 16'h0022, 16'h0EEE, 16'h0033, 16'h0004, 16'h0044};

  always_comb begin
    for (int e = 0; e < N_RATES; e++) tbl_rate[e*RATE_W +: RATE_W] = 16'(t_rate[e]);
    for (int s = 0; s < N_RATES*N_AUX; s++) begin
      tbl_aux_addr[s*ADDR_W +: ADDR_W] = 8'(t_addr[s]);
      tbl_aux_data[s*DATA_W +: DATA_W] = 16'(t_data[s]);
    end
  end

  cpu_rate_seq #(
    .RATE_W(RATE_W), .DIV_W(DIV_W), .N_RATES(N_RATES), .N_AUX(N_AUX),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CORE_ADDR(CORE), .PLL_TIMEOUT(TMO)
  ) i_cpu_rate_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_old_rate(req_old_rate), .req_new_rate(req_new_rate), .alt_rate(alt_rate),
    .tbl_rate(tbl_rate), .tbl_aux_addr(tbl_aux_addr), .tbl_aux_data(tbl_aux_data),
    .pll_req(pll_req), .pll_locked(pll_locked), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .busy(busy), .done(done),
    .err_badrate(err_badrate), .err_timeout(err_timeout), .core_rate(core_rate)
  );

  typedef struct {
    logic [7:0]  a;
    logic [15:0] d;
    logic [15:0] m;
    string       tag;
  } wr_t;
  wr_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected writes as they appear
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2", "unexpected write addr", longint'(wr_addr), -1);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        chk(wr_addr == e.a && wr_data == e.d && wr_mask == e.m, e.tag, "write addr/data/mask",
            {wr_addr, wr_data, wr_mask}, {e.a, e.d, e.m});
      end
    end
  end

  function automatic int exp_div(input int alt, input int old);
    int q;
    if (old == 0) return 15;
    q = (alt + old - 1) / old;
    return (q - 1 > 15) ? 15 : q - 1;
  endfunction

  function automatic int find_idx(input int rate);
    for (int e = 0; e < N_RATES; e++) if (t_rate[e] == rate) return e;
    return -1;
  endfunction

  task automatic push(input int a, input int d, input int m, input string tag);
    wr_t w;
    w.a = 8'(a); w.d = 16'(d); w.m = 16'(m); w.tag = tag;
    exp_q.push_back(w);
  endtask

  task automatic push_aux(input int idx, input string tag);
    for (int j = 0; j < N_AUX; j++)
      if (t_addr[idx*N_AUX+j] != 0)   // R10 empty slots skipped
        push(t_addr[idx*N_AUX+j], t_data[idx*N_AUX+j], 16'hFFFF, tag);
  endtask

  // Driver: computes expected write stream, runs one request
  task automatic run_req(input int old_r, input int new_r, input int alt_r,
                         input bit do_lock, input int lock_dly, input bit poke_busy,
                         input int wait_rate, input int after_rate, input string tag);
    int idx;
    idx = find_idx(new_r);
    if (idx >= 0) begin
      if (alt_r > old_r) push(CORE, 16'h10 | exp_div(alt_r, old_r), 16'h1F, "R3");
      else               push(CORE, 16'h10, 16'h10, "R5");
      if (do_lock) begin
        if (new_r > old_r) begin push_aux(idx, "R8"); push(CORE, 0, 16'h1F, "R7"); end
        else if (new_r < old_r) begin push(CORE, 0, 16'h1F, "R7"); push_aux(idx, "R9"); end
        else push(CORE, 0, 16'h1F, "R9");
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_old_rate = 16'(old_r); req_new_rate = 16'(new_r); alt_rate = 16'(alt_r);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R12", {tag, " busy after accept"}, busy, 1);
    while (!pll_req && !done) @(negedge clk);
    if (pll_req) begin
      chk(core_rate == 16'(wait_rate), "R11", {tag, " core_rate during wait"}, core_rate, wait_rate);
      if (poke_busy) begin
        req_valid = 1'b1; req_old_rate = 16'd1; req_new_rate = 16'd800; alt_rate = 16'd9000;
        @(negedge clk);
        req_valid = 1'b0;
      end
      if (do_lock) begin
        repeat (lock_dly) @(negedge clk);
        pll_locked = 1'b1;
      end
    end
    while (!done) @(negedge clk);
    pll_locked = 1'b0;
    chk(busy == 1'b0, "R12", {tag, " busy at done"}, busy, 0);
    chk(exp_q.size() == 0, tag, "writes missing", exp_q.size(), 0);
    exp_q.delete();
    chk(err_badrate == (idx < 0), "R2", {tag, " err_badrate"}, err_badrate, idx < 0);
    chk(err_timeout == (idx >= 0 && !do_lock), "R6", {tag, " err_timeout"}, err_timeout, idx >= 0 && !do_lock);
    @(negedge clk);
    chk(core_rate == 16'(after_rate), "R11", {tag, " core_rate after"}, core_rate, after_rate);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !wr_en && !pll_req, "R12", "reset outputs idle", {busy, wr_en, pll_req}, 0);
    chk(core_rate == 0, "R12", "reset core_rate", core_rate, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !wr_en, "R12", "idle after reset", {busy, wr_en}, 0);

    // R1 R3 R8 R10: raise, alt 3x old -> div 2; entry 2 slot 0 empty
    run_req(100, 400, 300, 1, 3, 0, 100, 400, "R1 raise");
    // R5 R9: lower, alt below old -> mux only; aux after switch-back
    run_req(800, 200, 300, 1, 0, 0, 300, 200, "R9 lower");
    // R9: equal rates, no aux
    run_req(200, 200, 250, 1, 2, 0, 125, 200, "R9 equal");
    // R4: ceil 100 -> clamped to 15
    run_req(10, 100, 1000, 1, 1, 0, 62, 100, "R4 clamp");
    // R3: non-integer ratio 250/100 -> ceil 3 -> div 2
    run_req(100, 800, 250, 1, 5, 0, 83, 800, "R3 ceil");
    // R2: rate not in table
    run_req(800, 150, 300, 1, 0, 0, 0, 800, "R2 bad");
    // R12: request during PLL wait ignored
    run_req(400, 100, 100, 1, 4, 1, 100, 100, "R12 ignore");
    // R6: no lock -> timeout, parked on alt/2
    run_req(100, 200, 150, 0, 0, 0, 75, 75, "R6 timeout");
    // R5: mux-only write keeps stale divider 1 from the timeout
    run_req(100, 400, 50, 1, 2, 0, 25, 400, "R5 stale div");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R12 watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule